// File: doc/BRIEF.md
# Banked RAM with Bulk Load and Save Side Port

This block is a one-write, one-read RAM assembled from several 512-row by 9-bit basic blocks. In normal operation it presents a single user word of `UW` bits (9, 18 or 36). The word is split into `UW/9` lanes, and each lane lives in its own basic block. Groups of lanes form banks. The upper user address bits choose the bank, and the low 9 bits choose the row. Read data is registered and appears on the clock edge after the read address.

A second interface serves an external non-volatile memory controller. With `load_en` high, the controller writes 9-bit words into the basic blocks at a shared side row. Each block has its own strobe, so each block is a separate client, and user writes are locked out. With `save_en` high, every block reads the shared side row on the read path. Each block returns its word on its own 9-bit output on the following edge, and no writes happen. If both modes are requested, load takes precedence.

Top module: `bsr_top`

## Requirements
- R1: While `rst_n` is low, `rd_data` and every `side_dout` lane read as zero.
- R2: With both side modes low, a user write stores `wr_data` at `wr_addr`. A read presented on `rd_addr` returns that word on `rd_data` one clock after the address. Address bits [8:0] are the row and the bits above are the bank. Lane j (`rd_data[9j+8:9j]`) is held in basic block `bank*(UW/9)+j`.
- R3: While `load_en` is high, each block i whose `side_we[i]` is high stores `side_din` at row `side_addr`.
- R4: While `load_en` is high, `wr_en` changes no stored word.
- R5: While `save_en` is high and `load_en` is low, `side_dout[9i+8:9i]` shows block i's word at row `side_addr` on the clock edge after that address is presented. Back-to-back addresses give back-to-back results.
- R6: While `save_en` is high and `load_en` is low, neither `wr_en` nor `side_we` changes any stored word.
- R7: With `load_en` and `save_en` both high, side strobes write exactly as in R3.
- R8: With both side modes low, `side_we` changes no stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset of the read registers |
| wr_en | input | 1 | User write strobe |
| wr_addr | input | AW | User write address (bank, row) |
| wr_data | input | UW | User write word |
| rd_addr | input | AW | User read address (bank, row) |
| rd_data | output | UW | User read word, one cycle after `rd_addr` |
| load_en | input | 1 | Bulk load mode, active high |
| save_en | input | 1 | Bulk save mode, active high |
| side_addr | input | 9 | Shared side row for load and save |
| side_din | input | 9 | Load data word |
| side_we | input | NBLK | Per-block load strobes |
| side_dout | output | NBLK*9 | Per-block save words, block i in bits [9i+8:9i] |

## Verification
The hardest situation to reach is one where the side modes must block a write that would otherwise land. The stimulus targets words whose contents are already known, raises the user strobe and every side strobe under the blocking mode, and then reads those words back through the user port. Back-to-back save addressing is also exercised: a new side row is presented every cycle, and each block's lane is checked one cycle after its address to confirm there is no hidden pipeline stage.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  localparam int unsigned BLK_W   = 9;
  localparam int unsigned ROW_AW  = 9;
  localparam int unsigned BLK_ROWS = 1 << ROW_AW;

  // number of 9-bit lanes one user word occupies
  function automatic int unsigned lanes_for(input int unsigned uw);
    return (uw + BLK_W - 1) / BLK_W;
  endfunction

  // bank index carried in the upper user address bits
  function automatic int unsigned bank_of(input logic [31:0] a);
    return a >> ROW_AW;
  endfunction

  // row index inside every basic block
  function automatic logic [ROW_AW-1:0] row_of(input logic [31:0] a);
    return a[ROW_AW-1:0];
  endfunction

  // basic block holding a given lane of a given bank
  function automatic int unsigned blk_of(input int unsigned bank,
                                         input int unsigned lane,
                                         input int unsigned lanes);
    return bank * lanes + lane;
  endfunction
endpackage

// File: rtl/bsr_blk.sv
module bsr_blk
  import bsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ROW_AW-1:0] waddr,
  input  logic [BLK_W-1:0]  wdata,
  input  logic [ROW_AW-1:0] raddr,
  output logic [BLK_W-1:0]  q
);
  logic [BLK_W-1:0] mem [BLK_ROWS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // single read register: data on the edge after the address, no extra stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= mem[raddr];
  end
endmodule

// File: rtl/bsr_portmux.sv
module bsr_portmux
  import bsr_pkg::*;
#(
  parameter int unsigned NBLK  = 4,
  parameter int unsigned UW    = 18,
  parameter int unsigned LANES = lanes_for(UW),
  parameter int unsigned AW    = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [AW-1:0]         wr_addr,
  input  logic [UW-1:0]         wr_data,
  input  logic [AW-1:0]         rd_addr,
  input  logic                  load_en,
  input  logic                  save_en,
  input  logic [ROW_AW-1:0]     side_addr,
  input  logic [BLK_W-1:0]      side_din,
  input  logic [NBLK-1:0]       side_we,
  output logic [NBLK-1:0]       blk_we,
  output logic [ROW_AW-1:0]     blk_waddr,
  output logic [NBLK*BLK_W-1:0] blk_wdata,
  output logic [ROW_AW-1:0]     blk_raddr,
  output logic                  mode_user,
  output logic                  mode_load,
  output logic                  mode_save
);
  // mode decode, load over save
  assign mode_load = load_en;
  assign mode_save = save_en & ~load_en;
  assign mode_user = ~load_en & ~save_en;

  logic              side_mode;
  int unsigned       wr_bank;
  assign side_mode = mode_load | mode_save;
  assign wr_bank   = bank_of(32'(wr_addr));

  assign blk_waddr = mode_load ? side_addr : row_of(32'(wr_addr));
  assign blk_raddr = side_mode ? side_addr : row_of(32'(rd_addr));

  for (genvar g = 0; g < NBLK; g++) begin : g_lane
    localparam int unsigned MY_BANK = g / LANES;
    localparam int unsigned MY_LANE = g % LANES;
    logic user_hit;
    assign user_hit = mode_user & wr_en & (wr_bank == MY_BANK);
    assign blk_we[g] = (mode_load & side_we[g]) | user_hit;
    assign blk_wdata[g*BLK_W +: BLK_W] =
      mode_load ? side_din : wr_data[MY_LANE*BLK_W +: BLK_W];
  end

  assert_save_blocks_writes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (save_en && !load_en) |-> (blk_we == '0));

  assert_load_only_strobes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |-> ((blk_we & ~side_we) == '0));

  assert_load_takes_strobes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && save_en) |-> (blk_we == side_we));

  assert_idle_ignores_strobes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !save_en && !wr_en) |-> (blk_we == '0));

  assert_user_write_lanes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !save_en && wr_en && (bank_of(32'(wr_addr)) < NBLK / LANES))
      |-> ($countones(blk_we) == LANES));

  assert_modes_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({mode_user, mode_load, mode_save}));
endmodule

// File: rtl/bsr_rdsel.sv
module bsr_rdsel
  import bsr_pkg::*;
#(
  parameter int unsigned NBLK  = 4,
  parameter int unsigned UW    = 18,
  parameter int unsigned LANES = lanes_for(UW),
  parameter int unsigned AW    = 10,
  parameter int unsigned BSW   = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [AW-1:0]         rd_addr,
  input  logic [NBLK*BLK_W-1:0] blk_q,
  output logic [UW-1:0]         rd_data
);
  localparam int unsigned BANKS = NBLK / LANES;
  logic [BSW-1:0] bank_q;

  // bank select follows the block read register by the same one cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bank_q <= '0;
    else        bank_q <= BSW'(bank_of(32'(rd_addr)));
  end

  always_comb begin
    rd_data = '0;
    for (int j = 0; j < int'(LANES); j++) begin
      rd_data[j*BLK_W +: BLK_W] =
        blk_q[blk_of(32'(bank_q), j, LANES)*BLK_W +: BLK_W];
    end
  end

  assert_bank_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(bank_q) < BANKS));
endmodule

// File: rtl/bsr_top.sv
module bsr_top
  import bsr_pkg::*;
#(
  parameter int unsigned NBLK = 4,
  parameter int unsigned UW   = 18,
  localparam int unsigned LANES = lanes_for(UW),
  localparam int unsigned BANKS = NBLK / LANES,
  localparam int unsigned BSW   = (BANKS > 1) ? $clog2(BANKS) : 1,
  localparam int unsigned AW    = ROW_AW + ((BANKS > 1) ? $clog2(BANKS) : 0)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [AW-1:0]         wr_addr,
  input  logic [UW-1:0]         wr_data,
  input  logic [AW-1:0]         rd_addr,
  output logic [UW-1:0]         rd_data,
  input  logic                  load_en,
  input  logic                  save_en,
  input  logic [ROW_AW-1:0]     side_addr,
  input  logic [BLK_W-1:0]      side_din,
  input  logic [NBLK-1:0]       side_we,
  output logic [NBLK*BLK_W-1:0] side_dout
);
  logic [NBLK-1:0]       blk_we;
  logic [ROW_AW-1:0]     blk_waddr;
  logic [NBLK*BLK_W-1:0] blk_wdata;
  logic [ROW_AW-1:0]     blk_raddr;
  logic [NBLK*BLK_W-1:0] blk_q;
  logic                  mode_user, mode_load, mode_save;

  bsr_portmux #(.NBLK(NBLK), .UW(UW), .LANES(LANES), .AW(AW)) u_mux (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .load_en(load_en), .save_en(save_en),
    .side_addr(side_addr), .side_din(side_din), .side_we(side_we),
    .blk_we(blk_we), .blk_waddr(blk_waddr), .blk_wdata(blk_wdata),
    .blk_raddr(blk_raddr),
    .mode_user(mode_user), .mode_load(mode_load), .mode_save(mode_save)
  );

  for (genvar g = 0; g < NBLK; g++) begin : g_blk
    bsr_blk u_blk (
      .clk(clk), .rst_n(rst_n),
      .we(blk_we[g]), .waddr(blk_waddr),
      .wdata(blk_wdata[g*BLK_W +: BLK_W]),
      .raddr(blk_raddr),
      .q(blk_q[g*BLK_W +: BLK_W])
    );
  end

  bsr_rdsel #(.NBLK(NBLK), .UW(UW), .LANES(LANES), .AW(AW), .BSW(BSW)) u_sel (
    .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr),
    .blk_q(blk_q), .rd_data(rd_data)
  );

  // save lanes come straight from each block's single read register
  assign side_dout = blk_q;

  assert_save_row_tracks_side_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mode_save |-> (blk_raddr == side_addr));

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> (side_dout == '0 && rd_data == '0));
endmodule

// File: tb/sim_bsr_top.sv
module sim_bsr_top;
  localparam int CLK_NS = 10;
  localparam int NBLK = 4;
  localparam int UW = 18;
  localparam int AW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [UW-1:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [UW-1:0] rd_data;
  logic load_en = 1'b0, save_en = 1'b0;
  logic [8:0] side_addr = '0;
  logic [8:0] side_din = '0;
  logic [NBLK-1:0] side_we = '0;
  logic [NBLK*9-1:0] side_dout;

  int nvec = 0, nbad = 0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  bsr_top #(.NBLK(NBLK), .UW(UW)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .load_en(load_en), .save_en(save_en), .side_addr(side_addr),
    .side_din(side_din), .side_we(side_we), .side_dout(side_dout)
  );

  // {block[1:0], row[8:0], data[8:0]}
  localparam logic [19:0] LOADS [8] = '{
    {2'd0, 9'd0,   9'h001}, {2'd1, 9'd0,   9'h1FE},
    {2'd2, 9'd0,   9'h0AA}, {2'd3, 9'd0,   9'h155},
    {2'd0, 9'd511, 9'h123}, {2'd1, 9'd511, 9'h0F0},
    {2'd2, 9'd300, 9'h1C3}, {2'd3, 9'd7,   9'h07E}
  };

  task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic user_write(input logic [AW-1:0] a, input logic [UW-1:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic user_read(input logic [AW-1:0] a, output logic [UW-1:0] d);
    @(negedge clk); rd_addr = a;
    @(negedge clk); d = rd_data;
  endtask

  // user address for lane j of a block index: bank = blk/2, lane = blk%2
  function automatic logic [AW-1:0] uaddr(input int blk, input logic [8:0] row);
    return {1'(blk / 2), row};
  endfunction

  initial begin
    logic [UW-1:0] w;
    logic [UW-1:0] w2;
    // R1: outputs held at zero in reset
    repeat (3) @(negedge clk);
    check("R1 rd_data", 36'(rd_data), 36'h0);
    check("R1 side_dout", 36'(side_dout), 36'h0);
    rst_n = 1'b1;

    // R3: table loaded through side strobes, read back through user port (R2)
    foreach (LOADS[i]) begin
      @(negedge clk);
      load_en = 1'b1; side_addr = LOADS[i][17:9]; side_din = LOADS[i][8:0];
      side_we = NBLK'(1) << LOADS[i][19:18];
    end
    @(negedge clk); side_we = '0; load_en = 1'b0;
    foreach (LOADS[i]) begin
      int b;
      b = int'(LOADS[i][19:18]);
      user_read(uaddr(b, LOADS[i][17:9]), w);
      check("R3 load via user", 36'(w[(b%2)*9 +: 9]), 36'(LOADS[i][8:0]));
    end

    // R5: each loaded word visible on its block lane one cycle after address
    foreach (LOADS[i]) begin
      int b;
      b = int'(LOADS[i][19:18]);
      @(negedge clk); save_en = 1'b1; side_addr = LOADS[i][17:9];
      @(negedge clk);
      check("R5 save lane", 36'(side_dout[b*9 +: 9]), 36'(LOADS[i][8:0]));
    end
    @(negedge clk); save_en = 1'b0;

    // R2: two banks at the same row hold separate words
    user_write({1'b1, 9'd5}, 18'h35A5);
    user_write({1'b0, 9'd5}, 18'h0C3C);
    user_read({1'b1, 9'd5}, w);
    check("R2 bank1 word", 36'(w), 36'h35A5);
    user_read({1'b0, 9'd5}, w);
    check("R2 bank0 word", 36'(w), 36'h0C3C);

    // R5: back-to-back save addressing, lane placement of a user word
    @(negedge clk); save_en = 1'b1; side_addr = 9'd0;
    @(negedge clk);
    check("R5 b2b row0 blk0", 36'(side_dout[0 +: 9]), 36'h001);
    side_addr = 9'd511;
    @(negedge clk);
    check("R5 b2b row511 blk1", 36'(side_dout[9 +: 9]), 36'h0F0);
    side_addr = 9'd5;
    @(negedge clk);
    w = 18'h35A5;
    check("R5 b2b row5 blk2", 36'(side_dout[18 +: 9]), 36'(w[8:0]));
    check("R5 b2b row5 blk3", 36'(side_dout[27 +: 9]), 36'(w[17:9]));
    save_en = 1'b0;

    // R4: user write ignored while loading
    @(negedge clk); load_en = 1'b1; side_we = '0;
    user_write({1'b1, 9'd5}, 18'h3FFFF);
    @(negedge clk); load_en = 1'b0;
    user_read({1'b1, 9'd5}, w);
    check("R4 user write blocked", 36'(w), 36'h35A5);

    // R6: every write source ignored while saving
    @(negedge clk); save_en = 1'b1; side_we = '1; side_addr = 9'd5; side_din = 9'h000;
    user_write({1'b0, 9'd5}, 18'h11111);
    @(negedge clk); save_en = 1'b0; side_we = '0;
    user_read({1'b0, 9'd5}, w);
    check("R6 bank0 kept", 36'(w), 36'h0C3C);
    user_read({1'b1, 9'd5}, w);
    check("R6 bank1 kept", 36'(w), 36'h35A5);

    // R7: both modes high, load wins
    @(negedge clk); load_en = 1'b1; save_en = 1'b1;
    side_addr = 9'd9; side_din = 9'h0C9; side_we = 4'b0011;
    @(negedge clk); side_we = '0; load_en = 1'b0; save_en = 1'b0;
    user_read({1'b0, 9'd9}, w);
    w2 = {9'h0C9, 9'h0C9};
    check("R7 load priority", 36'(w), 36'(w2));

    // R8: side strobe ignored with no side mode
    @(negedge clk); side_addr = 9'd9; side_din = 9'h111; side_we = 4'b0010;
    @(negedge clk); side_we = '0;
    user_read({1'b0, 9'd9}, w);
    check("R8 strobe ignored", 36'(w[17:9]), 36'h0C9);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nvec++; nbad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule